// File: doc/BRIEF.md
# Suspend Clock-Stop Handshake Sequencer

This block lets a fully static processor core have its system clock halted without losing state. It runs from an always-on reference clock and produces the core's system clock, which is the reference divided by two. A rising edge on the sleep request input starts the suspend sequence. The block first pulls an active-low suspend request towards the core. It then waits for the core's active-low suspend acknowledge. Only after the acknowledge has been seen does it raise a 3 V suspend output, which tells the board to stop its external clocks. It also parks its own clock output at a fixed level. While the clock is parked, the core cannot react to anything, so all wake handling is done here.

Three sources can end the suspend: an SMI event line, a wake pin, and an internal timer. On wake, the clock restart and the withdrawal of the suspend request happen in a fixed order that a parameter selects. A programmable gap of reference cycles separates the two steps. If a wake event arrives before the acknowledge has been seen, the attempt is abandoned and the clock is never gated. The clock enable only switches while the produced clock sits at its park level, so the gated clock never shows a short pulse.

Top module: `susp_clkstop_seq`

## Requirements
- R1: After reset, `core_susp_no` is 1, `susp3v_o` is 0, `clk_en_o` is 1, and `sys_clk_o` toggles on every reference clock edge.
- R2: When idle, a rising edge on `sleep_req_i` drives `core_susp_no` low at the next clock edge. At that moment `clk_en_o` stays 1 and `susp3v_o` stays 0.
- R3: `susp3v_o` rises only after the acknowledge is seen. This is exactly SYNC_STG+1 edges after the first edge that samples `core_ack_ni` low. Before that it stays 0.
- R4: Once `susp3v_o` is 1, `clk_en_o` clears at the first edge where `sys_clk_o` is at the level PARK_LVL. While `clk_en_o` is 0, `sys_clk_o` holds at PARK_LVL.
- R5: `clk_en_o` changes only at edges before which `sys_clk_o` was at PARK_LVL.
- R6: A synchronized wake (SMI or pin) while the block waits for the acknowledge aborts the attempt: `core_susp_no` returns to 1, and the clock is never gated. If the wake and the acknowledge are seen in the same cycle, the abort wins.
- R7: While the clock is stopped, any of these triggers wake: `wake_smi_i` or `wake_pin_i` held high (acted on SYNC_STG+1 edges after first being sampled), or the timer. With a nonzero `tmr_lim_i`, the timer keeps `clk_en_o` low for exactly `tmr_lim_i`+1 cycles. A `tmr_lim_i` of 0 disables the timer.
- R8: With CLK_FIRST=1, the wake edge sets `clk_en_o` and clears `susp3v_o` together. `core_susp_no` then rises `gap_i`+1 edges later.
- R9: With CLK_FIRST=0, the wake edge raises `core_susp_no`. `clk_en_o` then sets, together with `susp3v_o` clearing, `gap_i`+1 edges later.
- R10: After both wake steps, the block returns to idle once the synchronized `core_ack_ni` is high again. A new request is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Suspend request, acted on at its rising edge |
| core_ack_ni | input | 1 | Suspend acknowledge from the core, active low, synchronized |
| wake_smi_i | input | 1 | SMI wake event, level, synchronized |
| wake_pin_i | input | 1 | External wake pin, level, synchronized |
| tmr_lim_i | input | TMR_W | Wake timer length in cycles, 0 disables |
| gap_i | input | GAP_W | Gap between the two wake steps, minus one |
| core_susp_no | output | 1 | Suspend request to the core, active low |
| susp3v_o | output | 1 | 3 V suspend, stops the external clocks |
| clk_en_o | output | 1 | Glitch-free enable of the produced clock |
| sys_clk_o | output | 1 | Gated system clock for the core |

## Verification
Full suspend cycles are driven with random acknowledge delays, wake sources, gaps and timer lengths. Each cycle checks the exact edge of every output step, so a wrong latency in the synchronizers, the timer or the gap counter is caught. Directed cases cover the following situations:
- an abort before the acknowledge,
- a wake that arrives in the same cycle as the acknowledge,
- a long stop with the timer disabled,
- a second instance with the reverse wake order and a high park level.

Across all cycles, a monitor counts any enable change that is not at the park level. That count separates a glitch-free gate from one that switches mid-phase.

// File: rtl/susp_pkg.sv
package susp_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_REQ  = 3'd1,
      SQ_PARK = 3'd2,
      SQ_STOP = 3'd3,
      SQ_GAP  = 3'd4,
      SQ_REL  = 3'd5
   } sq_state_e;

endpackage

// File: rtl/susp_sync.sv
module susp_sync #(
   parameter int   WIDTH   = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
   end else begin : g_chain
      logic [WIDTH-1:0] stg_q [STAGES];

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= {WIDTH{RST_VAL}};
         end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
         end
      end

      assign q_o = stg_q[STAGES-1];
   end

endmodule

// File: rtl/susp_wake_tmr.sv
module susp_wake_tmr #(
   parameter int TMR_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             active_i,
   input  logic [TMR_W-1:0] lim_i,
   output logic             expire_o
);

   localparam logic [TMR_W-1:0] CNT_MAX = {TMR_W{1'b1}};

   logic [TMR_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!active_i) begin
         cnt_q <= '0;
      end else if (cnt_q != CNT_MAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire_o = active_i && (lim_i != '0) && (cnt_q == lim_i);

endmodule

// File: rtl/susp_clk_gate.sv
module susp_clk_gate #(
   parameter logic PARK_LVL = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic en_o,
   output logic clk_o
);

   logic en_q, en_d;
   logic ph_q, ph_d;

   // enable may only drop while the phase sits at the park level
   always_comb begin
      en_d = run_i | (en_q & (ph_q != PARK_LVL));
      ph_d = en_d ? ~ph_q : ph_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q <= 1'b1;
         ph_q <= PARK_LVL;
      end else begin
         en_q <= en_d;
         ph_q <= ph_d;
      end
   end

   assign en_o  = en_q;
   assign clk_o = ph_q;

endmodule

// File: rtl/susp_seq_fsm.sv
module susp_seq_fsm
   import susp_pkg::*;
#(
   parameter int GAP_W     = 4,
   parameter bit CLK_FIRST = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             req_i,
   input  logic             ack_sn_i,
   input  logic             wake_s_i,
   input  logic             tmr_exp_i,
   input  logic             clk_en_i,
   input  logic [GAP_W-1:0] gap_i,
   output logic             susp_no,
   output logic             s3v_o,
   output logic             run_o,
   output logic             tmr_act_o
);

   sq_state_e        st_q, st_d;
   logic             req_q;
   logic             susp_n_q, susp_n_d;
   logic             s3v_q, s3v_d;
   logic             run_q, run_d;
   logic [GAP_W-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d     = st_q;
      susp_n_d = susp_n_q;
      s3v_d    = s3v_q;
      run_d    = run_q;
      cnt_d    = cnt_q;
      unique case (st_q)
         SQ_IDLE: begin
            if (req_i && !req_q) begin
               st_d     = SQ_REQ;
               susp_n_d = 1'b0;
            end
         end
         SQ_REQ: begin
            if (wake_s_i) begin
               st_d     = SQ_IDLE;
               susp_n_d = 1'b1;
            end else if (!ack_sn_i) begin
               st_d  = SQ_PARK;
               s3v_d = 1'b1;
               run_d = 1'b0;
            end
         end
         SQ_PARK: begin
            if (!clk_en_i) st_d = SQ_STOP;
         end
         SQ_STOP: begin
            if (wake_s_i || tmr_exp_i) begin
               st_d  = SQ_GAP;
               cnt_d = gap_i;
               if (CLK_FIRST) begin
                  run_d = 1'b1;
                  s3v_d = 1'b0;
               end else begin
                  susp_n_d = 1'b1;
               end
            end
         end
         SQ_GAP: begin
            if (cnt_q == '0) begin
               st_d = SQ_REL;
               if (CLK_FIRST) begin
                  susp_n_d = 1'b1;
               end else begin
                  run_d = 1'b1;
                  s3v_d = 1'b0;
               end
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         SQ_REL: begin
            if (ack_sn_i) st_d = SQ_IDLE;
         end
         default: st_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= SQ_IDLE;
         req_q    <= 1'b0;
         susp_n_q <= 1'b1;
         s3v_q    <= 1'b0;
         run_q    <= 1'b1;
         cnt_q    <= '0;
      end else begin
         st_q     <= st_d;
         req_q    <= req_i;
         susp_n_q <= susp_n_d;
         s3v_q    <= s3v_d;
         run_q    <= run_d;
         cnt_q    <= cnt_d;
      end
   end

   assign susp_no   = susp_n_q;
   assign s3v_o     = s3v_q;
   assign run_o     = run_d;
   assign tmr_act_o = ((st_q == SQ_PARK) || (st_q == SQ_STOP)) && !clk_en_i;

endmodule

// File: rtl/susp_clkstop_seq.sv
module susp_clkstop_seq #(
   parameter int   SYNC_STG  = 2,
   parameter int   GAP_W     = 4,
   parameter int   TMR_W     = 8,
   parameter bit   CLK_FIRST = 1'b1,
   parameter logic PARK_LVL  = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             sleep_req_i,
   input  logic             core_ack_ni,
   input  logic             wake_smi_i,
   input  logic             wake_pin_i,
   input  logic [TMR_W-1:0] tmr_lim_i,
   input  logic [GAP_W-1:0] gap_i,
   output logic             core_susp_no,
   output logic             susp3v_o,
   output logic             clk_en_o,
   output logic             sys_clk_o
);

   localparam int WAKE_N = 2;

   if (SYNC_STG < 0 || SYNC_STG > 4) begin : g_bad_sync
      $error("SYNC_STG must lie in 0..4");
   end
   if (GAP_W < 1 || GAP_W > 16) begin : g_bad_gap
      $error("GAP_W must lie in 1..16");
   end
   if (TMR_W < 1 || TMR_W > 32) begin : g_bad_tmr
      $error("TMR_W must lie in 1..32");
   end

   logic              ack_sn;
   logic [WAKE_N-1:0] wake_raw, wake_sync;
   logic              wake_s;
   logic              tmr_exp, tmr_act;
   logic              run, en;

   assign wake_raw = {wake_pin_i, wake_smi_i};
   assign wake_s   = |wake_sync;

   susp_sync #(.WIDTH(1), .STAGES(SYNC_STG), .RST_VAL(1'b1)) u_ack_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (core_ack_ni),
      .q_o   (ack_sn)
   );

   susp_sync #(.WIDTH(WAKE_N), .STAGES(SYNC_STG), .RST_VAL(1'b0)) u_wake_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (wake_raw),
      .q_o   (wake_sync)
   );

   susp_wake_tmr #(.TMR_W(TMR_W)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .active_i(tmr_act),
      .lim_i   (tmr_lim_i),
      .expire_o(tmr_exp)
   );

   susp_seq_fsm #(.GAP_W(GAP_W), .CLK_FIRST(CLK_FIRST)) u_fsm (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .req_i    (sleep_req_i),
      .ack_sn_i (ack_sn),
      .wake_s_i (wake_s),
      .tmr_exp_i(tmr_exp),
      .clk_en_i (en),
      .gap_i    (gap_i),
      .susp_no  (core_susp_no),
      .s3v_o    (susp3v_o),
      .run_o    (run),
      .tmr_act_o(tmr_act)
   );

   susp_clk_gate #(.PARK_LVL(PARK_LVL)) u_gate (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run),
      .en_o  (en),
      .clk_o (sys_clk_o)
   );

   assign clk_en_o = en;

endmodule

// File: rtl/susp_clkstop_chk.sv
module susp_clkstop_chk #(
   parameter logic PARK_LVL = 1'b0
) (
   input logic clk_i,
   input logic rst_ni,
   input logic core_ack_ni,
   input logic core_susp_no,
   input logic susp3v_o,
   input logic clk_en_o,
   input logic sys_clk_o
);

   AST_REQ_WHILE_RUNNING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(core_susp_no) |-> (clk_en_o && !susp3v_o)); // R2

   AST_3V_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(susp3v_o) |-> (!core_susp_no && !core_ack_ni)); // R3

   AST_STOP_UNDER_3V: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clk_en_o |-> susp3v_o); // R4

   AST_CLK_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clk_en_o && !$past(clk_en_o)) |-> $stable(sys_clk_o)); // R4

   AST_EN_AT_PARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_en_o != $past(clk_en_o)) |-> ($past(sys_clk_o) == PARK_LVL)); // R5

   AST_RESTART_DROPS_3V: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_en_o) |-> $fell(susp3v_o)); // R8

endmodule

bind susp_clkstop_seq susp_clkstop_chk #(.PARK_LVL(PARK_LVL)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .core_ack_ni (core_ack_ni),
   .core_susp_no(core_susp_no),
   .susp3v_o    (susp3v_o),
   .clk_en_o    (clk_en_o),
   .sys_clk_o   (sys_clk_o)
);

// File: tb/susp_clkstop_seq_tb.sv
module susp_clkstop_seq_tb_top;

   localparam int GAP_W = 4;
   localparam int TMR_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   // instance A: default (clock first, park low)
   logic             req = 1'b0, ack_n = 1'b1, smi = 1'b0, pin = 1'b0;
   logic [TMR_W-1:0] lim = '0;
   logic [GAP_W-1:0] gap = '0;
   logic             susp_n, s3v, en, sclk;

   // instance B: suspend first, park high
   logic             b_req = 1'b0, b_ack_n = 1'b1, b_pin = 1'b0;
   logic             b_susp_n, b_s3v, b_en, b_sclk;

   int checks = 0;
   int errors = 0;
   int glitches = 0;
   bit done = 1'b0;

   susp_clkstop_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(req), .core_ack_ni(ack_n),
      .wake_smi_i(smi), .wake_pin_i(pin), .tmr_lim_i(lim), .gap_i(gap),
      .core_susp_no(susp_n), .susp3v_o(s3v), .clk_en_o(en), .sys_clk_o(sclk)
   );

   susp_clkstop_seq #(.CLK_FIRST(1'b0), .PARK_LVL(1'b1)) dut_b_i (
      .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(b_req), .core_ack_ni(b_ack_n),
      .wake_smi_i(1'b0), .wake_pin_i(b_pin), .tmr_lim_i(8'd0), .gap_i(4'd2),
      .core_susp_no(b_susp_n), .susp3v_o(b_s3v), .clk_en_o(b_en), .sys_clk_o(b_sclk)
   );

   // glitch monitor for both instances
   logic p_en = 1'b1, p_clk = 1'b0, pb_en = 1'b1, pb_clk = 1'b1;
   always @(negedge clk) begin
      if (rst_n) begin
         if (en != p_en && p_clk != 1'b0) glitches++;
         if (b_en != pb_en && pb_clk != 1'b1) glitches++;
      end
      p_en = en; p_clk = sclk; pb_en = b_en; pb_clk = b_sclk;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n = 1);
      repeat (n) begin
         @(posedge clk);
         #5;
      end
   endtask

   function automatic int exp_gap_edges(input int g);
      return g + 1;
   endfunction

   function automatic int exp_tmr_low(input int l);
      return l + 1;
   endfunction

   // one full suspend cycle on instance A; src 0 smi, 1 pin, 2 timer
   task automatic full_cycle(input int src, input int g, input int ackd,
                             input int l, input int hold);
      int k;
      bit en_at3v;
      lim = (src == 2) ? l[TMR_W-1:0] : '0;
      gap = g[GAP_W-1:0];
      req = 1'b1;
      step();
      req = 1'b0;
      chk(susp_n == 1'b0, "R2/R10 susp request", susp_n, 0);
      chk(en == 1'b1 && s3v == 1'b0, "R2 clock runs at request", en, 1);
      for (int i = 0; i < ackd; i++) begin
         step();
         chk(s3v == 1'b0, "R3 no 3V before ack", s3v, 0);
      end
      ack_n = 1'b0;
      step(2);
      chk(s3v == 1'b0, "R3 3V latency early", s3v, 0);
      step();
      chk(s3v == 1'b1, "R3 3V after ack", s3v, 1);
      en_at3v = en;
      step();
      chk(en == 1'b0, "R4 clock stopped", en, 0);
      chk(sclk == 1'b0, "R4 park level", sclk, 0);
      if (src == 2) begin
         k = en_at3v ? 1 : 2;
         for (int i = 0; i < 400 && en == 1'b0; i++) begin
            step();
            if (en == 1'b0) k++;
         end
         chk(k == exp_tmr_low(l), "R7 timer stop length", k, exp_tmr_low(l));
      end else begin
         step(hold);
         chk(en == 1'b0, "R7 no wake without source", en, 0);
         if (src == 0) smi = 1'b1; else pin = 1'b1;
         step(2);
         chk(en == 1'b0, "R7 wake sync latency", en, 0);
         step();
         chk(en == 1'b1, "R7 wake restarts clock", en, 1);
      end
      chk(s3v == 1'b0, "R8 3V drops with restart", s3v, 0);
      chk(susp_n == 1'b0 || g < 0, "R8 request still held", susp_n, 0);
      k = 0;
      for (int i = 0; i < 40 && susp_n == 1'b0; i++) begin
         step();
         k++;
      end
      chk(k == exp_gap_edges(g), "R8 gap to release", k, exp_gap_edges(g));
      smi = 1'b0;
      pin = 1'b0;
      ack_n = 1'b1;
      step(4);
   endtask

   initial begin
      int k;
      void'($urandom(32'd20240611));
      step(3);
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk(susp_n == 1'b1, "R1 reset susp", susp_n, 1);
      chk(s3v == 1'b0, "R1 reset 3V", s3v, 0);
      chk(en == 1'b1 && b_en == 1'b1, "R1 reset enable", en, 1);
      k = sclk;
      step();
      chk(sclk != k[0], "R1 clock toggles", sclk, ~k[0]);

      // directed: smi, pin with long hold (timer disabled), timer, zero gap
      full_cycle(0, 0, 0, 0, 2);
      full_cycle(1, 5, 3, 0, 60);
      full_cycle(2, 2, 1, 1, 0);
      full_cycle(2, 15, 2, 9, 0);

      // R6 abort before ack
      req = 1'b1; step(); req = 1'b0;
      smi = 1'b1;
      step(2);
      chk(susp_n == 1'b0, "R6 request held before abort", susp_n, 0);
      step();
      chk(susp_n == 1'b1, "R6 abort releases", susp_n, 1);
      chk(s3v == 1'b0 && en == 1'b1, "R6 abort keeps clock", en, 1);
      smi = 1'b0;
      step(3);

      // R6 wake and ack seen in the same cycle
      req = 1'b1; step(); req = 1'b0;
      ack_n = 1'b0; pin = 1'b1;
      step(3);
      chk(susp_n == 1'b1, "R6 tie abort", susp_n, 1);
      chk(s3v == 1'b0, "R6 tie no 3V", s3v, 0);
      pin = 1'b0; ack_n = 1'b1;
      step(4);
      chk(en == 1'b1 && s3v == 1'b0, "R6 tie clock never gated", en, 1);

      // random cycles
      for (int n = 0; n < 30; n++) begin
         full_cycle($urandom_range(2, 0), $urandom_range(15, 0),
                    $urandom_range(5, 0), $urandom_range(20, 1),
                    $urandom_range(6, 0));
      end

      // instance B: suspend released first, clock parked high
      b_req = 1'b1; step(); b_req = 1'b0;
      chk(b_susp_n == 1'b0, "R2 B request", b_susp_n, 0);
      b_ack_n = 1'b0;
      for (int i = 0; i < 10 && b_en == 1'b1; i++) step();
      chk(b_en == 1'b0 && b_sclk == 1'b1, "R4 B parked high", b_sclk, 1);
      step(3);
      b_pin = 1'b1;
      step(2);
      chk(b_susp_n == 1'b0, "R9 B sync latency", b_susp_n, 0);
      step();
      chk(b_susp_n == 1'b1 && b_en == 1'b0, "R9 B release first", b_susp_n, 1);
      k = 0;
      for (int i = 0; i < 20 && b_en == 1'b0; i++) begin
         step();
         k++;
      end
      chk(k == exp_gap_edges(2), "R9 B gap to restart", k, exp_gap_edges(2));
      chk(b_s3v == 1'b0, "R9 B 3V drops with restart", b_s3v, 0);
      b_pin = 1'b0; b_ack_n = 1'b1;
      step(4);
      b_req = 1'b1; step(); b_req = 1'b0;
      chk(b_susp_n == 1'b0, "R10 B new request", b_susp_n, 0);
      step(2);

      chk(glitches == 0, "R5 enable changes at park level", glitches, 0);
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL R10 watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule